// File: doc/BRIEF.md
# DMA Request and Service Interrupt Controller

This block decides, cycle by cycle, whether a FIFO-based parallel port asks the host for an ISA-style DMA transfer, and when it raises the pulsed service interrupt. It reads the DMA enable bit, the active-low service-interrupt enable bit (held in a host register outside the block), the port direction, a FIFO test-mode flag and the FIFO status flags. It drives the request line with its tristate enable, a fixed-width interrupt pulse, and a one-cycle request that tells the register outside to set the service bit high.

A burst is cut after a set number of consecutive acknowledged data cycles. It restarts by itself once the acknowledge is released. A terminal count during an acknowledged cycle ends DMA until software writes the service bit back to 0. With DMA off, the same interrupt path reports that the FIFO has crossed its threshold. While the acknowledge is low, host write and read strobes become FIFO push and pop strobes.

The controller is a four-state machine. ST_IDLE waits for a request condition or a threshold event. ST_REQ drives the request. ST_HOLD waits for the acknowledge to rise after a burst limit. ST_LOCK waits for the service bit to read back high after an interrupt. The transitions are: IDLE to REQ when a request condition holds; IDLE to LOCK on a threshold event; REQ to IDLE when the condition is lost; REQ to HOLD at the burst limit; REQ or HOLD to LOCK on a terminal count; HOLD to IDLE when the acknowledge rises or DMA is disabled; LOCK to IDLE once the service bit is high.

Top module: `dsc_ctrl`

## Requirements
- R1: After reset, `drq`, `irq_pulse` and `svc_set` are 0.
- R2: `drq` goes high when `dma_en`=1, `svc_n`=0, and one of these holds: `dir_rev`=0 with `fifo_full`=0, `dir_rev`=1 with `fifo_empty`=0, or `test_mode`=1.
- R3: `drq` drops while the FIFO is full (forward) or empty (reverse), and returns by itself once that flag clears.
- R4: `drq` drops after `svc_n` goes high and returns after `svc_n` is written back to 0.
- R5: After BURST_MAX (default 32) consecutive DMA data cycles (a `host_wr` or `host_rd` strobe while `dack_n`=0), `drq` drops. It stays low until `dack_n` rises, which clears the count, and then reasserts by itself.
- R6: A rising edge on `tc` while `dack_n`=0 and `dma_en`=1 produces one interrupt pulse and a one-cycle `svc_set`. After that, `drq` stays low until `svc_n` has read high and has then been written back to 0.
- R7: With `dma_en`=0 and `svc_n`=0, an interrupt pulse and `svc_set` fire when `room_ge8`=1 (at least 8 free entries) with `dir_rev`=0, or when `fill_ge8`=1 (at least 8 filled entries) with `dir_rev`=1. The other flag has no effect in each direction.
- R8: Every interrupt pulse lasts exactly PULSE_CYCLES clock cycles (default 5, about 208 ns at 24 MHz). `svc_set` is high in its first cycle.
- R9: `drq_oe` equals `dma_en`. `drq` is low from the cycle after `dma_en` is 0.
- R10: `fifo_push` equals `host_wr` and `fifo_pop` equals `host_rd` while `dack_n`=0. Both are 0 while `dack_n`=1.
- R11: `tc` is synchronized. A `tc` edge while `dack_n`=1 is ignored, and `tc` held high does not fire a second time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (nominal 24 MHz) |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_en | input | 1 | DMA enable bit |
| svc_n | input | 1 | Service-interrupt bit, 0 = enabled |
| dir_rev | input | 1 | Port direction, 1 = reverse (peripheral to host) |
| test_mode | input | 1 | FIFO test mode active |
| fifo_full | input | 1 | FIFO full flag |
| fifo_empty | input | 1 | FIFO empty flag |
| room_ge8 | input | 1 | At least 8 free FIFO entries |
| fill_ge8 | input | 1 | At least 8 filled FIFO entries |
| dack_n | input | 1 | DMA acknowledge, active low |
| tc | input | 1 | Terminal count, asynchronous |
| host_wr | input | 1 | Host write strobe, one cycle per transfer |
| host_rd | input | 1 | Host read strobe, one cycle per transfer |
| drq | output | 1 | DMA request |
| drq_oe | output | 1 | Drive enable for the request line |
| irq_pulse | output | 1 | Service interrupt pulse |
| svc_set | output | 1 | One-cycle request to set the service bit |
| fifo_push | output | 1 | Push strobe to the FIFO |
| fifo_pop | output | 1 | Pop strobe from the FIFO |

## Verification
The request path is driven with forward, reverse and test-mode settings, each with the relevant FIFO flag toggled. This separates direction-correct flag selection from a design that looks at the wrong flag. A run of exactly BURST_MAX strobes followed by an acknowledge release separates a correct burst limit from an off-by-one count or a missing automatic restart. Terminal-count edges are applied with the acknowledge low, with it high, and held high. This distinguishes a proper synchronized edge detector from level detection or a missing acknowledge qualifier. Threshold events are offered with both free-space and fill flags in both directions, so a design that ignores the direction is caught.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_HOLD = 2'd2,
        ST_LOCK = 2'd3
    } dsc_state_t;
endpackage

// File: rtl/dsc_tc_sync.sv
module dsc_tc_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tc_async,
    output logic tc_rise
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], tc_async};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign tc_rise = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/dsc_burst_cnt.sv
module dsc_burst_cnt #(
    parameter int BURST_MAX = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dack_n,
    input  logic xfer,
    output logic limit
);
    localparam int CW = $clog2(BURST_MAX + 1);
    localparam logic [CW-1:0] LIMIT_VAL = CW'(BURST_MAX);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (dack_n) begin
            cnt_q <= '0;
        end else if (xfer && (cnt_q != LIMIT_VAL)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign limit = (cnt_q == LIMIT_VAL);
endmodule

// File: rtl/dsc_pulse_gen.sv
module dsc_pulse_gen #(
    parameter int PULSE_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic pulse
);
    localparam int PW = $clog2(PULSE_CYCLES + 1);
    localparam logic [PW-1:0] LOAD_VAL = PW'(PULSE_CYCLES);

    logic [PW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= LOAD_VAL;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign pulse = (left_q != '0);
endmodule

// File: rtl/dsc_ctrl.sv
module dsc_ctrl
    import dsc_pkg::*;
#(
    parameter int BURST_MAX    = 32,
    parameter int PULSE_CYCLES = 5,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dma_en,
    input  logic svc_n,
    input  logic dir_rev,
    input  logic test_mode,
    input  logic fifo_full,
    input  logic fifo_empty,
    input  logic room_ge8,
    input  logic fill_ge8,
    input  logic dack_n,
    input  logic tc,
    input  logic host_wr,
    input  logic host_rd,
    output logic drq,
    output logic drq_oe,
    output logic irq_pulse,
    output logic svc_set,
    output logic fifo_push,
    output logic fifo_pop
);
    dsc_state_t state_q, state_d;
    logic       fire;
    logic       tc_rise;
    logic       burst_hit;
    logic       flow_ok;
    logic       thr_ok;
    logic       tc_hit;

    dsc_tc_sync #(.SYNC_STAGES(SYNC_STAGES)) u_tc_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .tc_async (tc),
        .tc_rise  (tc_rise)
    );

    dsc_burst_cnt #(.BURST_MAX(BURST_MAX)) u_burst (
        .clk    (clk),
        .rst_n  (rst_n),
        .dack_n (dack_n),
        .xfer   (host_wr | host_rd),
        .limit  (burst_hit)
    );

    dsc_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .start (fire),
        .pulse (irq_pulse)
    );

    // Conditions seen by the state machine
    assign flow_ok = test_mode | (dir_rev ? ~fifo_empty : ~fifo_full);
    assign thr_ok  = dir_rev ? fill_ge8 : room_ge8;
    assign tc_hit  = tc_rise & ~dack_n & dma_en;

    // Next state and interrupt trigger
    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (tc_hit) begin
                    state_d = ST_LOCK;
                    fire    = 1'b1;
                end else if (!dma_en && !svc_n && thr_ok) begin
                    state_d = ST_LOCK;
                    fire    = 1'b1;
                end else if (dma_en && !svc_n && flow_ok) begin
                    state_d = ST_REQ;
                end
            end
            ST_REQ: begin
                if (tc_hit) begin
                    state_d = ST_LOCK;
                    fire    = 1'b1;
                end else if (!dma_en || svc_n || !flow_ok) begin
                    state_d = ST_IDLE;
                end else if (burst_hit) begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (tc_hit) begin
                    state_d = ST_LOCK;
                    fire    = 1'b1;
                end else if (dack_n || !dma_en) begin
                    state_d = ST_IDLE;
                end
            end
            ST_LOCK: begin
                if (svc_n) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            svc_set <= 1'b0;
        end else begin
            svc_set <= fire;
        end
    end

    assign drq       = (state_q == ST_REQ);
    assign drq_oe    = dma_en;
    assign fifo_push = ~dack_n & host_wr;
    assign fifo_pop  = ~dack_n & host_rd;
endmodule

// File: rtl/dsc_ctrl_chk.sv
module dsc_ctrl_chk #(
    parameter int BURST_MAX    = 32,
    parameter int PULSE_CYCLES = 5
) (
    input logic clk,
    input logic rst_n,
    input logic dma_en,
    input logic dack_n,
    input logic host_wr,
    input logic host_rd,
    input logic drq,
    input logic drq_oe,
    input logic irq_pulse,
    input logic svc_set
);
    localparam int CW = $clog2(BURST_MAX + 2);
    localparam int HW = $clog2(PULSE_CYCLES + 2) + 1;

    logic [CW-1:0] seen_q;
    logic [HW-1:0] high_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
            high_q <= '0;
        end else begin
            if (dack_n)
                seen_q <= '0;
            else if ((host_wr || host_rd) && (seen_q < CW'(BURST_MAX)))
                seen_q <= seen_q + 1'b1;
            if (irq_pulse)
                high_q <= high_q + 1'b1;
            else
                high_q <= '0;
        end
    end

    assert_oe_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !drq_oe |=> !drq);

    assert_set_in_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        svc_set |-> irq_pulse);

    assert_pulse_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pulse) |-> svc_set);

    assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_pulse) |-> (high_q == HW'(PULSE_CYCLES)));

    assert_burst_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q >= CW'(BURST_MAX)) |=> !drq);

    assert_disabled_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_en && !drq) |=> !drq);
endmodule

bind dsc_ctrl dsc_ctrl_chk #(
    .BURST_MAX    (BURST_MAX),
    .PULSE_CYCLES (PULSE_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dma_en    (dma_en),
    .dack_n    (dack_n),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .drq       (drq),
    .drq_oe    (drq_oe),
    .irq_pulse (irq_pulse),
    .svc_set   (svc_set)
);

// File: tb/dsc_ctrl_tb.sv
module dsc_ctrl_tb;
    localparam int CLK_PERIOD = 42;
    localparam int BURST      = 32;
    localparam int PW         = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dma_en = 0, svc_reg = 0, dir_rev = 0, test_mode = 0;
    logic fifo_full = 0, fifo_empty = 1, room_ge8 = 0, fill_ge8 = 0;
    logic dack_n = 1, tc = 0, host_wr = 0, host_rd = 0;
    logic drq, drq_oe, irq_pulse, svc_set, fifo_push, fifo_pop;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    logic in_pulse = 0;
    int width = 0;
    logic done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsc_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .svc_n(svc_reg),
        .dir_rev(dir_rev), .test_mode(test_mode), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty), .room_ge8(room_ge8), .fill_ge8(fill_ge8),
        .dack_n(dack_n), .tc(tc), .host_wr(host_wr), .host_rd(host_rd),
        .drq(drq), .drq_oe(drq_oe), .irq_pulse(irq_pulse), .svc_set(svc_set),
        .fifo_push(fifo_push), .fifo_pop(fifo_pop)
    );

    // Host register model: hardware set of the service bit
    always @(posedge clk) if (rst_n && svc_set) svc_reg <= 1'b1;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Monitor: every interrupt pulse is matched against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_pulse) begin
                if (!in_pulse) begin
                    in_pulse = 1;
                    width = 0;
                    chk("R8 svc_set at pulse start", svc_set, 1'b1);
                end
                width++;
            end else if (in_pulse) begin
                in_pulse = 0;
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R6/R7 unexpected pulse actual=%0d expected=none", width);
                end else begin
                    int w;
                    w = exp_q.pop_front();
                    if (w != width) begin
                        errors++;
                        $display("FAIL R8 pulse width actual=%0d expected=%0d", width, w);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        finish_run();
    end

    initial begin
        tick(3);
        chk("R1 drq reset", drq, 1'b0);
        chk("R1 irq reset", irq_pulse, 1'b0);
        chk("R1 svc_set reset", svc_set, 1'b0);
        rst_n = 1;
        tick(2);

        // R9: disabled -> no drive
        chk("R9 oe off", drq_oe, 1'b0);
        dir_rev = 0; fifo_full = 0;
        tick(3);
        chk("R9 no drq when disabled", drq, 1'b0);

        // R2 forward
        dma_en = 1;
        tick(2);
        chk("R9 oe on", drq_oe, 1'b1);
        chk("R2 forward not full", drq, 1'b1);
        // R3 full stops, clear restarts
        fifo_full = 1; tick(2);
        chk("R3 full drops", drq, 1'b0);
        fifo_full = 0; tick(2);
        chk("R3 restart after full", drq, 1'b1);
        // R2 reverse
        dir_rev = 1; fifo_empty = 1; tick(2);
        chk("R3 reverse empty drops", drq, 1'b0);
        fifo_empty = 0; tick(2);
        chk("R2 reverse not empty", drq, 1'b1);
        // R2 test mode
        fifo_empty = 1; test_mode = 1; tick(2);
        chk("R2 test mode", drq, 1'b1);
        test_mode = 0; tick(2);
        chk("R2 test mode off", drq, 1'b0);
        dir_rev = 0; fifo_full = 0; tick(2);
        // R4 service bit
        svc_reg = 1; tick(2);
        chk("R4 svc high drops", drq, 1'b0);
        svc_reg = 0; tick(2);
        chk("R4 svc low restarts", drq, 1'b1);
        // R9 disable drops
        dma_en = 0; tick(2);
        chk("R9 disable drops", drq, 1'b0);
        dma_en = 1; tick(2);

        // R10 strobes
        host_wr = 1; #1;
        chk("R10 no push with dack high", fifo_push, 1'b0);
        host_wr = 0;
        dack_n = 0; host_rd = 1; #1;
        chk("R10 pop with dack low", fifo_pop, 1'b1);
        host_rd = 0;

        // R5 burst limit
        for (int i = 0; i < BURST; i++) begin
            host_wr = 1; #1;
            if (i == 0) chk("R10 push with dack low", fifo_push, 1'b1);
            tick(1);
            host_wr = 0;
            if (i == BURST - 2) chk("R5 still requesting before limit", drq, 1'b1);
        end
        tick(2);
        chk("R5 drq low after limit", drq, 1'b0);
        dack_n = 1; tick(3);
        chk("R5 restart after dack release", drq, 1'b1);

        // R11 tc with dack high ignored
        tc = 1; tick(6);
        chk("R11 tc ignored with dack high", svc_reg, 1'b0);
        chk("R11 drq kept", drq, 1'b1);
        tc = 0; tick(3);

        // R6 tc during acknowledged cycle
        dack_n = 0;
        exp_q.push_back(PW);
        tc = 1; tick(5);
        chk("R6 svc bit set", svc_reg, 1'b1);
        chk("R6 drq stopped", drq, 1'b0);
        tick(8);
        chk("R6 drq stays low", drq, 1'b0);
        svc_reg = 0; tick(3);
        chk("R6 software re-arm", drq, 1'b1);
        tick(6);
        chk("R11 held tc no refire", svc_reg, 1'b0);
        tc = 0; dack_n = 1; tick(3);

        // R7 threshold forward
        dma_en = 0; tick(2);
        dir_rev = 0; fill_ge8 = 1; tick(4);
        chk("R7 fill ignored forward", svc_reg, 1'b0);
        fill_ge8 = 0;
        exp_q.push_back(PW);
        room_ge8 = 1; tick(3);
        chk("R7 forward threshold sets svc", svc_reg, 1'b1);
        room_ge8 = 0; tick(8);
        // R7 threshold reverse
        dir_rev = 1; room_ge8 = 1; svc_reg = 0; tick(4);
        chk("R7 room ignored reverse", svc_reg, 1'b0);
        room_ge8 = 0;
        exp_q.push_back(PW);
        fill_ge8 = 1; tick(3);
        chk("R7 reverse threshold sets svc", svc_reg, 1'b1);
        fill_ge8 = 0; tick(10);

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8 missing pulses actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end
endmodule